// File: doc/BRIEF.md
# USB 2.0 L1 Sleep Entry Responder

This block sits on the device side of a USB 2.0 link. It answers a host request to put the link into the L1 sleep state and then tracks the link through sleep and wake-up. Each request carries a 4-bit resume-duration code and a remote-wake permission bit. The block turns the code into microseconds and checks that figure against the longest exit latency the device can tolerate. It also looks at whether any endpoint still has work. From these it returns an accept or a reject handshake one cycle after the request.

After an accepted request the link sits in L1. Either side can end the sleep. The host ends it by sending resume signalling, which the block sees as a level detect. The device ends it by raising a wake request, which only works when remote wake was granted in the accepted request. The block keeps the decoded duration of the accepted request on an output, so other logic in the device can size its own power-down to match. Packet coding and the PHY are handled elsewhere.

Top module: `lpm_l1_responder`

## Requirements
- R1: After reset, `link_state` is 0 (L0), `hs_valid` is 0, `drive_resume` is 0 and `hird_us` is 0.
- R2: A resume-duration code c decodes to 50 + 75*c microseconds (code 0 gives 50, code 15 gives 1175). `hird_us` shows the decoded value of the most recently accepted request.
- R3: A request sampled in L0 gives `hs_valid` high for exactly one cycle, in the cycle after the request. `hs_code` is 1 for accept (ACK) and 2 for reject (NYET).
- R4: A non-periodic device rejects a request when the decoded duration is greater than `MAX_EXIT_US`. A duration equal to the limit is accepted when no endpoint is busy.
- R5: A non-periodic device rejects a request while any bit of `ep_busy` is set.
- R6: With `periodic_mode` high, every request in L0 is accepted, whatever the duration and the endpoint state.
- R7: An accept moves `link_state` to 1 (L1) in the same cycle as the handshake. A reject leaves the link in L0 and leaves `hird_us` unchanged.
- R8: In L1, `resume_det` high moves `link_state` to 2 (resume) on the next cycle. The link returns to L0 on the cycle after `resume_det` is sampled low.
- R9: In L1 with remote wake granted, `wake_req` moves the link to resume and holds `drive_resume` high for exactly `RESUME_CYC` cycles. The link then returns to L0.
- R10: In L1 without remote wake granted, `wake_req` has no effect: the link stays in L1 and `drive_resume` stays low.
- R11: A request sampled while the link is not in L0 gets no handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe: host L1 request received |
| req_hird | input | 4 | Resume-duration code carried by the request |
| req_rwake | input | 1 | Remote-wake permission carried by the request |
| ep_busy | input | NUM_EP | Per-endpoint pending-work flags |
| periodic_mode | input | 1 | Device has periodic endpoints; always accept |
| resume_det | input | 1 | Host resume signalling detected on the bus |
| wake_req | input | 1 | Device-internal wake request |
| hs_valid | output | 1 | Handshake valid, one cycle |
| hs_code | output | 2 | Handshake code: 1 ACK, 2 NYET |
| link_state | output | 2 | 0 L0, 1 L1, 2 resume |
| hird_us | output | 11 | Latched decoded resume duration in microseconds |
| drive_resume | output | 1 | Device drives resume signalling |

## Verification
A wrong state register shows up at once as a wrong `link_state` code. It also shows in handshakes: a request that should be answered gets none, or a request that should get none is answered, on the next cycle. A bad compare or decode shows as the wrong handshake code one cycle after the request. It also shows as a wrong `hird_us` value in that same cycle. A wrong remote-wake latch or resume counter shows first as `drive_resume` rising when it should not. Otherwise it shows as `drive_resume` staying high one cycle too long or too short, so the fault is seen within `RESUME_CYC` cycles of the wake request.

// File: rtl/lpm_l1_pkg.sv
package lpm_l1_pkg;
  localparam int HIRD_W       = 4;
  localparam int HIRD_BASE_US = 50;
  localparam int HIRD_STEP_US = 75;
  localparam int US_W = $clog2(HIRD_BASE_US + HIRD_STEP_US * ((1 << HIRD_W) - 1) + 1);

  typedef enum logic [1:0] {
    HS_NONE = 2'd0,
    HS_ACK  = 2'd1,
    HS_NYET = 2'd2
  } hs_code_e;

  typedef enum logic [1:0] {
    LNK_L0     = 2'd0,
    LNK_L1     = 2'd1,
    LNK_RESUME = 2'd2
  } link_e;

  typedef enum logic [1:0] {
    ST_L0,
    ST_L1,
    ST_RES_HOST,
    ST_RES_DEV
  } fsm_e;
endpackage

// File: rtl/lpm_hird_decode.sv
module lpm_hird_decode
  import lpm_l1_pkg::*;
(
  input  logic [HIRD_W-1:0] code,
  output logic [US_W-1:0]   dur_us
);
  // linear map: base plus one step per code increment
  always_comb begin
    dur_us = US_W'(HIRD_BASE_US) + US_W'(HIRD_STEP_US) * US_W'(code);
  end
endmodule

// File: rtl/lpm_accept_policy.sv
module lpm_accept_policy
  import lpm_l1_pkg::*;
#(
  parameter int NUM_EP      = 4,
  parameter int MAX_EXIT_US = 500
) (
  input  logic [US_W-1:0]   dur_us,
  input  logic [NUM_EP-1:0] ep_busy,
  input  logic              periodic_mode,
  output logic              accept
);
  logic [31:0] dur_ext;
  logic        too_slow;
  logic        any_busy;

  always_comb begin
    dur_ext  = 32'(dur_us);
    too_slow = dur_ext > 32'(MAX_EXIT_US);
    any_busy = |ep_busy;
    // periodic devices override both the latency and the activity checks
    accept   = periodic_mode | (~too_slow & ~any_busy);
  end
endmodule

// File: rtl/lpm_link_fsm.sv
module lpm_link_fsm
  import lpm_l1_pkg::*;
#(
  parameter int RESUME_CYC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            accept,
  input  logic [US_W-1:0] dur_us,
  input  logic            req_rwake,
  input  logic            resume_det,
  input  logic            wake_req,
  output logic            hs_valid,
  output logic [1:0]      hs_code,
  output logic [1:0]      link_state,
  output logic [US_W-1:0] hird_us,
  output logic            drive_resume
);
  localparam int CNT_W = $clog2(RESUME_CYC + 1);

  fsm_e            st;
  hs_code_e        hs_q;
  logic            hs_v_q;
  logic [US_W-1:0] hird_q;
  logic            rwake_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_L0;
      hs_v_q  <= 1'b0;
      hs_q    <= HS_NONE;
      hird_q  <= '0;
      rwake_q <= 1'b0;
      cnt     <= '0;
    end else begin
      hs_v_q <= 1'b0;
      hs_q   <= HS_NONE;
      case (st)
        ST_L0: begin
          if (req_valid) begin
            hs_v_q <= 1'b1;
            if (accept) begin
              hs_q    <= HS_ACK;
              st      <= ST_L1;
              hird_q  <= dur_us;
              rwake_q <= req_rwake;
            end else begin
              hs_q <= HS_NYET;
            end
          end
        end
        ST_L1: begin
          if (resume_det) begin
            st <= ST_RES_HOST;
          end else if (wake_req && rwake_q) begin
            st  <= ST_RES_DEV;
            cnt <= CNT_W'(RESUME_CYC - 1);
          end
        end
        ST_RES_HOST: begin
          if (!resume_det) st <= ST_L0;
        end
        ST_RES_DEV: begin
          if (cnt == '0) st <= ST_L0;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_L0;
      endcase
    end
  end

  always_comb begin
    hs_valid     = hs_v_q;
    hs_code      = hs_q;
    hird_us      = hird_q;
    drive_resume = (st == ST_RES_DEV);
    case (st)
      ST_L0:   link_state = LNK_L0;
      ST_L1:   link_state = LNK_L1;
      default: link_state = LNK_RESUME;
    endcase
  end
endmodule

// File: rtl/lpm_l1_responder.sv
module lpm_l1_responder
  import lpm_l1_pkg::*;
#(
  parameter int NUM_EP      = 4,
  parameter int MAX_EXIT_US = 500,
  parameter int RESUME_CYC  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [HIRD_W-1:0] req_hird,
  input  logic              req_rwake,
  input  logic [NUM_EP-1:0] ep_busy,
  input  logic              periodic_mode,
  input  logic              resume_det,
  input  logic              wake_req,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic [1:0]        link_state,
  output logic [US_W-1:0]   hird_us,
  output logic              drive_resume
);
  logic [US_W-1:0] dur_us;
  logic            accept;

  lpm_hird_decode u_dec (
    .code   (req_hird),
    .dur_us (dur_us)
  );

  lpm_accept_policy #(
    .NUM_EP      (NUM_EP),
    .MAX_EXIT_US (MAX_EXIT_US)
  ) u_pol (
    .dur_us        (dur_us),
    .ep_busy       (ep_busy),
    .periodic_mode (periodic_mode),
    .accept        (accept)
  );

  lpm_link_fsm #(
    .RESUME_CYC (RESUME_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .accept       (accept),
    .dur_us       (dur_us),
    .req_rwake    (req_rwake),
    .resume_det   (resume_det),
    .wake_req     (wake_req),
    .hs_valid     (hs_valid),
    .hs_code      (hs_code),
    .link_state   (link_state),
    .hird_us      (hird_us),
    .drive_resume (drive_resume)
  );
endmodule

// File: rtl/lpm_l1_responder_chk.sv
module lpm_l1_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       periodic_mode,
  input logic       hs_valid,
  input logic [1:0] hs_code,
  input logic [1:0] link_state,
  input logic       drive_resume
);
  // R3
  hs_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |=> !hs_valid);

  // R3
  hs_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(req_valid));

  // R6
  periodic_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && periodic_mode && link_state == 2'd0) |=> (hs_valid && hs_code == 2'd1));

  // R7
  ack_enters_l1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == 2'd1) |-> link_state == 2'd1);

  // R7
  nyet_stays_l0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == 2'd2) |-> link_state == 2'd0);

  // R8
  l1_no_direct_l0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_state == 2'd1 |=> link_state != 2'd0);

  // R9
  drive_in_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_resume |-> link_state == 2'd2);

  // R11
  no_hs_outside_l0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && link_state != 2'd0) |=> !hs_valid);
endmodule

bind lpm_l1_responder lpm_l1_responder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .periodic_mode (periodic_mode),
  .hs_valid      (hs_valid),
  .hs_code       (hs_code),
  .link_state    (link_state),
  .drive_resume  (drive_resume)
);

// File: tb/lpm_l1_responder_tb.sv
`timescale 1ns/1ps
module lpm_l1_responder_tb;
  localparam int NUM_EP      = 4;
  localparam int MAX_EXIT_US = 500;
  localparam int RESUME_CYC  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [3:0]        req_hird = '0;
  logic              req_rwake = 1'b0;
  logic [NUM_EP-1:0] ep_busy = '0;
  logic              periodic_mode = 1'b0;
  logic              resume_det = 1'b0;
  logic              wake_req = 1'b0;
  logic              hs_valid;
  logic [1:0]        hs_code;
  logic [1:0]        link_state;
  logic [10:0]       hird_us;
  logic              drive_resume;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  lpm_l1_responder #(
    .NUM_EP(NUM_EP), .MAX_EXIT_US(MAX_EXIT_US), .RESUME_CYC(RESUME_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hird(req_hird),
    .req_rwake(req_rwake), .ep_busy(ep_busy), .periodic_mode(periodic_mode),
    .resume_det(resume_det), .wake_req(wake_req), .hs_valid(hs_valid),
    .hs_code(hs_code), .link_state(link_state), .hird_us(hird_us),
    .drive_resume(drive_resume)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_req(input logic [3:0] h, input logic rw,
                          output int vld, output int code, output int lnk);
    @(negedge clk);
    req_valid = 1'b1; req_hird = h; req_rwake = rw;
    @(negedge clk);
    vld = int'(hs_valid); code = int'(hs_code); lnk = int'(link_state);
    req_valid = 1'b0;
  endtask

  task automatic host_wake(input string req);
    @(negedge clk); resume_det = 1'b1;
    @(negedge clk); chk(req, int'(link_state), 2);
    resume_det = 1'b0;
    @(negedge clk); chk(req, int'(link_state), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 link", int'(link_state), 0);
    chk("R1 hs_valid", int'(hs_valid), 0);
    chk("R1 drive", int'(drive_resume), 0);
    chk("R1 hird_us", int'(hird_us), 0);
  endtask

  task automatic t_decode;
    int v, c, l;
    send_req(4'd0, 1'b0, v, c, l);
    chk("R3 valid", v, 1);
    chk("R7 ack code", c, 1);
    chk("R7 link L1", l, 1);
    chk("R2 code0", int'(hird_us), 50);
    @(negedge clk); chk("R3 one cycle", int'(hs_valid), 0);
    host_wake("R8 host resume");
    // R4 boundary: code 6 decodes to exactly the limit
    send_req(4'd6, 1'b0, v, c, l);
    chk("R4 equal accepted", c, 1);
    chk("R2 code6", int'(hird_us), 500);
    host_wake("R8 host resume");
  endtask

  task automatic t_latency;
    int v, c, l;
    send_req(4'd7, 1'b0, v, c, l);
    chk("R4 valid", v, 1);
    chk("R4 over limit nyet", c, 2);
    chk("R7 stays L0", l, 0);
    chk("R7 hird unchanged", int'(hird_us), 500);
  endtask

  task automatic t_busy;
    int v, c, l;
    ep_busy = 4'b0010;
    send_req(4'd0, 1'b0, v, c, l);
    chk("R5 busy nyet", c, 2);
    chk("R5 stays L0", l, 0);
    ep_busy = '0;
  endtask

  task automatic t_periodic;
    int v, c, l;
    ep_busy = 4'b1001; periodic_mode = 1'b1;
    send_req(4'd15, 1'b0, v, c, l);
    chk("R6 periodic ack", c, 1);
    chk("R6 link L1", l, 1);
    chk("R2 code15", int'(hird_us), 1175);
    ep_busy = '0; periodic_mode = 1'b0;
    host_wake("R8 host resume");
  endtask

  task automatic t_dev_wake;
    int v, c, l, n;
    send_req(4'd2, 1'b1, v, c, l);
    chk("R9 accept", c, 1);
    chk("R2 code2", int'(hird_us), 200);
    @(negedge clk); wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
    chk("R9 resume state", int'(link_state), 2);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (drive_resume) n++;
      @(negedge clk);
    end
    chk("R9 drive length", n, RESUME_CYC);
    chk("R9 back to L0", int'(link_state), 0);
  endtask

  task automatic t_no_wake;
    int v, c, l;
    send_req(4'd1, 1'b0, v, c, l);
    chk("R10 accept", c, 1);
    @(negedge clk); wake_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 stays L1", int'(link_state), 1);
    chk("R10 no drive", int'(drive_resume), 0);
    wake_req = 1'b0;
    // R11: request while asleep is not answered
    send_req(4'd0, 1'b0, v, c, l);
    chk("R11 no handshake", v, 0);
    chk("R11 still L1", l, 1);
    host_wake("R8 host resume");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_latency();
    t_busy();
    t_periodic();
    t_dev_wake();
    t_no_wake();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule